// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM LED Dimmer

This block is a bank of pulse-width-modulated LED outputs. It is programmed through a plain parallel write port that carries an address, a data byte and a one-cycle write strobe. Every channel has an 8-bit brightness value and an enable bit. All channels share one free-running 8-bit period counter. A brightness write is held in a staging copy and has no effect on the output yet. A write to the commit address arms a transfer that moves every staged value into the live duty registers together. The transfer happens at the next period boundary, so no channel ever emits a cut-short or stretched pulse.

There are three chip-wide controls on top of the per-channel settings. A run bit holds all outputs low while it is cleared. A kill bit forces all outputs low while it is set. A soft-reset address puts every register back to its power-on value. The register map is write-only. Software keeps its own copy of what it wrote.

Top module: `pwm_led_bank`

## Requirements
- R1: After reset all outputs are low. The run bit is cleared, every staged and live duty is 0, every channel enable is 0, the kill bit is 0 and no commit is armed.
- R2: While a channel is enabled, the run bit is 1 and the kill bit is 0, its output is high in exactly D of every 256 consecutive cycles, where D is the live duty. The output is high while the shared counter is below D. D=0 gives no high cycle and D=255 gives 255.
- R3: A write to address n (1 to 36) stores the data byte as the staged duty of channel n only. Until a commit takes effect, the output keeps its previous live duty.
- R4: A write of any data to address 0x25 arms a commit. The copy from staged to live takes place on the clock edge where the counter wraps from 255 to 0, so within 256 cycles. A period that has already started finishes with the old duty.
- R5: A commit moves the staged values as they stand at the wrap. Duty writes and commit writes may be interleaved in any order, and the final live duties equal the last staged values.
- R6: Bit 0 of address 0x25+n (0x26 to 0x49) is the enable of channel n and takes effect on the next cycle. A disabled channel's output is low, and its duty values are kept.
- R7: Bit 0 of address 0x00 is the run bit. While it is 0 every output is low. Setting it to 1 again restores outputs from the retained duties and enables.
- R8: Bit 0 of address 0x4A is the kill bit. While it is 1 every output is low whatever the per-channel settings. Writing 0 restores normal operation.
- R9: A write of any data to address 0x4F returns all registers to their R1 values. This covers the staged duties, live duties, enables, run bit, kill bit, any armed commit and the period counter.
- R10: Writes to 0x4B to 0x4E and to 0x50 to 0xFF change no register and no output.
- R11: Channels are independent. A duty or enable write to one channel changes no other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per register write |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 36 | One PWM output per channel, bit i is channel i+1 |

## Verification
A corrupted live duty shows within one 256-cycle period as a wrong count of high cycles on that channel's output. A commit that fires off the wrap point shows as a period whose high count is neither the old duty nor the new one. The bench catches this by locking onto a one-cycle marker pulse from a channel set to duty 1. A lost or stray enable, run or kill state shows on the very next cycle as outputs that are low when they should toggle, or that toggle when they should be low. A staging copy that leaks through before a commit shows the new duty in the first full period after the write.

// File: rtl/pld_pkg.sv
package pld_pkg;

  localparam int unsigned DUTY_W = 8;
  typedef logic [DUTY_W-1:0] duty_t;

  localparam int unsigned SD_ADDR   = 0;
  localparam int unsigned DUTY_BASE = 1;

  function automatic int unsigned commit_addr(int unsigned nch);
    return DUTY_BASE + nch;
  endfunction

  function automatic int unsigned ctrl_base(int unsigned nch);
    return commit_addr(nch) + 1;
  endfunction

  function automatic int unsigned kill_addr(int unsigned nch);
    return ctrl_base(nch) + nch;
  endfunction

  function automatic int unsigned srst_addr(int unsigned nch);
    return kill_addr(nch) + 5;
  endfunction

  // output level for one channel given the shared counter and its gates
  function automatic logic pwm_level(duty_t cnt, duty_t duty, logic en,
                                     logic run, logic kill);
    return en && run && !kill && (cnt < duty);
  endfunction

endpackage

// File: rtl/pld_decode.sv
module pld_decode
  import pld_pkg::*;
#(
  parameter int unsigned NUM_CH = 36,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] duty_wr,
  output logic [NUM_CH-1:0] ctrl_wr,
  output logic              commit_wr,
  output logic              sd_wr,
  output logic              kill_wr,
  output logic              srst_wr,
  output logic              unmapped_wr
);

  localparam int unsigned A_COMMIT = commit_addr(NUM_CH);
  localparam int unsigned A_CTRL   = ctrl_base(NUM_CH);
  localparam int unsigned A_KILL   = kill_addr(NUM_CH);
  localparam int unsigned A_SRST   = srst_addr(NUM_CH);

  logic [31:0] a_u;
  logic        any_hit;

  assign a_u = 32'(wr_addr);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign duty_wr[i] = wr_en && (a_u == DUTY_BASE + i);
    assign ctrl_wr[i] = wr_en && (a_u == A_CTRL + i);
  end

  assign commit_wr = wr_en && (a_u == A_COMMIT);
  assign sd_wr     = wr_en && (a_u == SD_ADDR);
  assign kill_wr   = wr_en && (a_u == A_KILL);
  assign srst_wr   = wr_en && (a_u == A_SRST);

  assign any_hit     = (|duty_wr) || (|ctrl_wr) || commit_wr || sd_wr ||
                       kill_wr || srst_wr;
  assign unmapped_wr = wr_en && !any_hit;

endmodule

// File: rtl/pld_timebase.sv
module pld_timebase
  import pld_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst,
  input  logic  commit_wr,
  output duty_t cnt,
  output logic  commit_armed,
  output logic  commit_evt
);

  logic wrap;

  assign wrap       = (cnt == {DUTY_W{1'b1}});
  assign commit_evt = wrap && commit_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      commit_armed <= 1'b0;
    end else if (srst) begin
      cnt          <= '0;
      commit_armed <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (commit_evt)
        commit_armed <= commit_wr;
      else if (commit_wr)
        commit_armed <= 1'b1;
    end
  end

endmodule

// File: rtl/pld_channel.sv
module pld_channel
  import pld_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst,
  input  logic  duty_wr,
  input  logic  ctrl_wr,
  input  duty_t wr_data,
  input  logic  commit_evt,
  input  duty_t cnt,
  input  logic  run,
  input  logic  kill,
  output logic  en,
  output logic  pwm
);

  duty_t staged;
  duty_t live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= '0;
      live   <= '0;
      en     <= 1'b0;
    end else if (srst) begin
      staged <= '0;
      live   <= '0;
      en     <= 1'b0;
    end else begin
      if (duty_wr)    staged <= wr_data;
      if (commit_evt) live   <= staged;
      if (ctrl_wr)    en     <= wr_data[0];
    end
  end

  assign pwm = pwm_level(cnt, live, en, run, kill);

endmodule

// File: rtl/pwm_led_bank.sv
module pwm_led_bank
  import pld_pkg::*;
#(
  parameter int unsigned NUM_CH = 36,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [NUM_CH-1:0] duty_wr;
  logic [NUM_CH-1:0] ctrl_wr;
  logic [NUM_CH-1:0] en_vec;
  logic              commit_wr;
  logic              sd_wr;
  logic              kill_wr;
  logic              srst_wr;
  logic              unmapped_wr;
  logic              commit_armed;
  logic              commit_evt;
  logic              run_q;
  logic              kill_q;
  duty_t             cnt;

  pld_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .duty_wr     (duty_wr),
    .ctrl_wr     (ctrl_wr),
    .commit_wr   (commit_wr),
    .sd_wr       (sd_wr),
    .kill_wr     (kill_wr),
    .srst_wr     (srst_wr),
    .unmapped_wr (unmapped_wr)
  );

  pld_timebase u_tb (
    .clk          (clk),
    .rst_n        (rst_n),
    .srst         (srst_wr),
    .commit_wr    (commit_wr),
    .cnt          (cnt),
    .commit_armed (commit_armed),
    .commit_evt   (commit_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      kill_q <= 1'b0;
    end else if (srst_wr) begin
      run_q  <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      if (sd_wr)   run_q  <= wr_data[0];
      if (kill_wr) kill_q <= wr_data[0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pld_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst       (srst_wr),
      .duty_wr    (duty_wr[i]),
      .ctrl_wr    (ctrl_wr[i]),
      .wr_data    (wr_data),
      .commit_evt (commit_evt),
      .cnt        (cnt),
      .run        (run_q),
      .kill       (kill_q),
      .en         (en_vec[i]),
      .pwm        (pwm_out[i])
    );
  end

endmodule

// File: rtl/pld_checker.sv
module pld_checker
  import pld_pkg::*;
#(
  parameter int unsigned NUM_CH = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srst_wr,
  input logic              commit_wr,
  input logic              unmapped_wr,
  input logic              commit_evt,
  input logic              commit_armed,
  input duty_t             cnt,
  input logic              run_q,
  input logic              kill_q,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] pwm_out
);

  AST_RUN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> pwm_out == '0); // R7

  AST_KILL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    kill_q |-> pwm_out == '0); // R8

  AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwm_out & ~en_vec) == 0); // R6

  AST_COMMIT_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> cnt == '0); // R4

  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_wr && !srst_wr) |=> commit_armed); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_wr |=> cnt == $past(cnt) + 1'b1); // R2

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (!run_q && !kill_q && en_vec == '0 && !commit_armed &&
                 cnt == '0 && pwm_out == '0)); // R9

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> $stable({run_q, kill_q, en_vec})); // R10

endmodule

bind pwm_led_bank pld_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .srst_wr      (srst_wr),
  .commit_wr    (commit_wr),
  .unmapped_wr  (unmapped_wr),
  .commit_evt   (commit_evt),
  .commit_armed (commit_armed),
  .cnt          (cnt),
  .run_q        (run_q),
  .kill_q       (kill_q),
  .en_vec       (en_vec),
  .pwm_out      (pwm_out)
);

// File: tb/test_pwm_led_bank.sv
`timescale 1ns/1ps
module test_pwm_led_bank;

  localparam int NCH      = 36;
  localparam int A_COMMIT = 8'h25;
  localparam int A_KILL   = 8'h4A;
  localparam int A_SRST   = 8'h4F;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [7:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  int hi [NCH];

  always #2.5 clk = ~clk;

  pwm_led_bank i_pwm_led_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 8'(addr);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_duty(int ch, int d);   // channel ch is 1-based
    wr(ch, d);
  endtask

  task automatic set_en(int ch, int e);
    wr(A_COMMIT + ch, e);
  endtask

  task automatic commit_and_settle();
    wr(A_COMMIT, 8'h00);
    repeat (258) @(negedge clk);
  endtask

  // count high samples per channel over one full 256-cycle window
  task automatic measure();
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi[c]++;
    end
  endtask

  task automatic t_reset_state();
    chk("R1 outputs low at reset", int'(pwm_out), 0);
    measure();
    for (int c = 0; c < NCH; c++) chk("R1 idle channel", hi[c], 0);
    wr(8'h00, 1);
    set_en(1, 1);
    measure();
    chk("R1 default duty is zero", hi[0], 0);
  endtask

  task automatic t_staging_and_levels();
    set_en(2, 1);
    set_en(NCH, 1);
    set_duty(1, 8'h40);
    set_duty(2, 8'hFF);
    set_duty(NCH, 8'h01);
    measure();
    chk("R3 staged ch1 not yet live", hi[0], 0);
    chk("R3 staged ch2 not yet live", hi[1], 0);
    commit_and_settle();
    measure();
    chk("R2 ch1 duty 64", hi[0], 64);
    chk("R2 ch2 duty 255", hi[1], 255);
    chk("R2 ch36 duty 1", hi[NCH-1], 1);
    chk("R11 ch3 untouched", hi[2], 0);
    set_duty(1, 0);
    commit_and_settle();
    measure();
    chk("R2 duty 0 never high", hi[0], 0);
    chk("R11 ch2 kept after ch1 change", hi[1], 255);
  endtask

  task automatic t_interleave();
    set_duty(1, 10);
    wr(A_COMMIT, 0);
    set_duty(2, 30);
    wr(A_COMMIT, 0);
    set_duty(1, 20);
    commit_and_settle();
    measure();
    chk("R5 latest ch1 value", hi[0], 20);
    chk("R5 interleaved ch2 value", hi[1], 30);
  endtask

  task automatic t_no_glitch();
    int p1;
    int p2;
    set_duty(1, 128);
    set_duty(NCH, 1);
    commit_and_settle();
    // lock onto the one-cycle marker that ch36 emits when the counter is 0
    do @(negedge clk); while (!pwm_out[NCH-1]);
    p1 = 0;
    for (int k = 0; k < 256; k++) begin
      if (pwm_out[0]) p1++;
      if (k == 100) begin wr_en = 1'b1; wr_addr = 8'd1; wr_data = 8'd16; end
      if (k == 101) begin wr_addr = 8'(A_COMMIT); wr_data = 8'd0; end
      if (k == 102) wr_en = 1'b0;
      @(negedge clk);
    end
    p2 = 0;
    for (int k = 0; k < 256; k++) begin
      if (pwm_out[0]) p2++;
      @(negedge clk);
    end
    chk("R4 running period keeps old duty", p1, 128);
    chk("R4 next period uses new duty", p2, 16);
  endtask

  task automatic t_enable();
    set_en(2, 0);
    measure();
    chk("R6 disabled ch2 low", hi[1], 0);
    chk("R11 ch1 unaffected by ch2 enable", hi[0], 16);
    set_en(2, 1);
    measure();
    chk("R6 re-enabled ch2 keeps duty", hi[1], 30);
  endtask

  task automatic t_run_and_kill();
    wr(8'h00, 0);
    measure();
    chk("R7 shutdown ch1", hi[0], 0);
    chk("R7 shutdown ch2", hi[1], 0);
    wr(8'h00, 1);
    measure();
    chk("R7 resume ch1", hi[0], 16);
    wr(A_KILL, 1);
    measure();
    chk("R8 kill ch1", hi[0], 0);
    chk("R8 kill ch2", hi[1], 0);
    wr(A_KILL, 0);
    measure();
    chk("R8 release ch2", hi[1], 30);
  endtask

  task automatic t_unmapped();
    wr(8'h4B, 8'hFF);
    wr(8'h4C, 8'h00);
    wr(8'h4D, 8'h01);
    wr(8'h4E, 8'hFF);
    wr(8'h50, 8'h00);
    wr(8'hFF, 8'h00);
    commit_and_settle();
    measure();
    chk("R10 ch1 after unmapped writes", hi[0], 16);
    chk("R10 ch2 after unmapped writes", hi[1], 30);
    chk("R10 ch36 after unmapped writes", hi[NCH-1], 1);
  endtask

  task automatic t_soft_reset();
    set_duty(1, 99);
    wr(A_COMMIT, 0);
    wr(A_SRST, 8'h5A);
    measure();
    chk("R9 all low after soft reset", hi[0] + hi[1] + hi[NCH-1], 0);
    wr(8'h00, 1);
    measure();
    chk("R9 enables cleared", hi[1], 0);
    set_en(1, 1);
    set_en(2, 1);
    commit_and_settle();
    measure();
    chk("R9 staged ch1 cleared", hi[0], 0);
    chk("R9 staged ch2 cleared", hi[1], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_staging_and_levels();
    t_interleave();
    t_no_glitch();
    t_enable();
    t_run_and_kill();
    t_unmapped();
    t_soft_reset();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
  end

endmodule